// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Recognition

This block recovers asynchronous serial characters from a line sampled on a 16x tick. A falling edge arms it. Half a bit later the low level is checked again. Each data bit, least significant first, and the stop bit are then decided by a vote of three samples near the middle of the bit. A control input selects eight or nine data bits per character. In nine-bit mode the last data bit goes to a separate output bit.

Finished characters appear on a valid/ready output. `rd_valid_o` doubles as the receiver-full flag. It stays high and holds the data until a cycle with `rd_ready_i` high. The receiver has no storage beyond this one slot, so back-pressure cannot stall the line. A character that completes while the slot is still occupied is dropped and raises the overrun flag.

A character whose data bits and stop bit are all zero is a break. A break sets the full, framing-error and break flags together and loads zero into the data and ninth-bit outputs. The error flags are sticky. They clear when a status-read pulse is followed by a later data handshake.

Top module: `urx_break_rx`

## Requirements
- R1: After reset, `rd_valid_o`, `fe_o`, `ovr_o` and `brk_o` are 0, and `rd_data_o` and `bit9_o` are 0.
- R2: A low level on the line that has gone high again 8 ticks after the falling edge is detected is discarded; no character is produced.
- R3: In eight-bit mode (`nine_bit_i`=0) the eight bits after the start bit are delivered LSB first on `rd_data_o`, and `bit9_o` is 0. A glitch that reaches only one of the three samples of a bit does not change that bit.
- R4: In nine-bit mode (`nine_bit_i`=1) the first eight data bits go to `rd_data_o` LSB first and the ninth goes to `bit9_o`.
- R5: `rd_valid_o` rises when a character completes. It falls one cycle after a cycle with `rd_valid_o` and `rd_ready_i` both high. While it is high and `rd_ready_i` is low, `rd_data_o` is held, unless a break arrives.
- R6: A non-break character that completes while `rd_valid_o` is high sets `ovr_o` and leaves `rd_data_o` and `bit9_o` unchanged.
- R7: A stop bit sampled 0 with any nonzero data bit (ninth included) sets `fe_o`, loads the data, and leaves `brk_o` at 0.
- R8: A break (start, 8 or 9 zero data bits per mode, stop sampled 0) sets `rd_valid_o`, `fe_o` and `brk_o`, and forces `rd_data_o` and `bit9_o` to 0.
- R9: A break that arrives while `rd_valid_o` is high also sets `ovr_o`.
- R10: After any stop bit sampled 0, no new start is accepted until the line has been seen high. A line held low after a break produces no further character.
- R11: `fe_o`, `brk_o` and `ovr_o` clear only on a data handshake that comes after a `stat_rd_i` pulse. A handshake with no `stat_rd_i` pulse before it leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit_i | input | 1 | 1 selects nine data bits per character |
| rd_data_o | output | 8 | Received data bits |
| rd_valid_o | output | 1 | Character held, receiver full |
| rd_ready_i | input | 1 | Consumer takes the character |
| bit9_o | output | 1 | Ninth data bit |
| stat_rd_i | input | 1 | Status-read pulse, arms flag clearing |
| fe_o | output | 1 | Framing error, sticky |
| ovr_o | output | 1 | Overrun, sticky |
| brk_o | output | 1 | Break received, sticky |

## Verification
The line passes through a two-stage synchronizer. The stop-bit vote is registered in the framer and then in the status registers. Character results therefore land a few cycles after the middle of the stop bit. The bench compares nothing while a frame is in flight. It updates its reference 80 cycles into the stop bit and then compares every output on every falling clock edge. A handshake or status-read pulse is driven just after one rising edge. Its effect is due at the next rising edge, and the reference is updated just after that edge, so each comparison at the falling edge between them sees the settled result.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_WAITH
  } urx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          nine_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o,
  output logic          stop_o,
  output logic          brk_o
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int NB   = DW + 1;
  localparam int BW   = $clog2(NB + 1);

  urx_state_e    st;
  logic [CW-1:0] cnt, cnt_nx;
  logic [BW-1:0] bidx, last_idx;
  logic [NB-1:0] sh, sh_nx;
  logic [1:0]    smp;
  logic          nine_q, vote;
  logic [DW-1:0] dat_w;
  logic          b9_w, zero_w;

  assign cnt_nx   = cnt + 1'b1;
  assign vote     = (smp[0] & smp[1]) | (smp[0] & rx_i) | (smp[1] & rx_i);
  assign last_idx = nine_q ? BW'(NB - 1) : BW'(DW - 1);
  assign sh_nx    = {vote, sh[NB-1:1]};
  assign dat_w    = nine_q ? sh[DW-1:0] : sh[NB-1:1];
  assign b9_w     = nine_q & sh[NB-1];
  assign zero_w   = (dat_w == '0) && !b9_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      smp    <= '0;
      nine_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      b9_o   <= 1'b0;
      stop_o <= 1'b1;
      brk_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st)
          S_IDLE: if (!rx_i) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: begin
            if (cnt == CW'(HALF - 1)) begin
              if (!rx_i) begin
                st     <= S_DATA;
                cnt    <= '0;
                bidx   <= '0;
                nine_q <= nine_i;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt_nx;
            end
          end
          S_DATA, S_STOP: begin
            cnt <= cnt_nx;
            if (cnt_nx == CW'(OSR - 2)) smp[0] <= rx_i;
            if (cnt_nx == CW'(OSR - 1)) smp[1] <= rx_i;
            if (cnt_nx == '0) begin
              if (st == S_DATA) begin
                sh <= sh_nx;
                if (bidx == last_idx) st <= S_STOP;
                else bidx <= bidx + 1'b1;
              end else begin
                done_o <= 1'b1;
                stop_o <= vote;
                brk_o  <= !vote && zero_w;
                data_o <= dat_w;
                b9_o   <= b9_w;
                st     <= vote ? S_IDLE : S_WAITH;
              end
            end
          end
          S_WAITH: if (rx_i) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_wait_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITH && !rx_i) |=> (st == S_WAITH));
  assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick_i && cnt == CW'(HALF - 1) && rx_i) |=> (st == S_IDLE && !done_o));
  assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/urx_status.sv
module urx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          b9_i,
  input  logic          stop_i,
  input  logic          brk_i,
  input  logic          ready_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          b9_o,
  output logic          fe_o,
  output logic          ovr_o,
  output logic          brk_o
);
  logic arm, take, full_eff;

  assign take     = valid_o & ready_i;
  assign full_eff = valid_o & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      b9_o    <= 1'b0;
      fe_o    <= 1'b0;
      ovr_o   <= 1'b0;
      brk_o   <= 1'b0;
      arm     <= 1'b0;
    end else begin
      if (stat_rd_i) arm <= 1'b1;
      if (take) begin
        valid_o <= 1'b0;
        arm     <= 1'b0;
        if (arm) begin
          fe_o  <= 1'b0;
          ovr_o <= 1'b0;
          brk_o <= 1'b0;
        end
      end
      if (done_i) begin
        if (brk_i) begin
          valid_o <= 1'b1;
          data_o  <= '0;
          b9_o    <= 1'b0;
          fe_o    <= 1'b1;
          brk_o   <= 1'b1;
          if (full_eff) ovr_o <= 1'b1;
        end else if (full_eff) begin
          ovr_o <= 1'b1;
        end else begin
          valid_o <= 1'b1;
          data_o  <= data_i;
          b9_o    <= b9_i;
          if (!stop_i) fe_o <= 1'b1;
        end
      end
    end
  end

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !(done_i && brk_i)) |=> ($stable(data_o) && $stable(b9_o) && valid_o));
  assert_break_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && brk_i) |=> (fe_o && brk_o && valid_o && data_o == '0 && !b9_o));
  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && valid_o && !ready_i) |=> ovr_o);
  assert_brk_has_fe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> fe_o);
endmodule

// File: rtl/urx_break_rx.sv
module urx_break_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          nine_bit_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic          bit9_o,
  input  logic          stat_rd_i,
  output logic          fe_o,
  output logic          ovr_o,
  output logic          brk_o
);
  logic          rx_s, f_done, f_b9, f_stop, f_brk;
  logic [DW-1:0] f_data;

  urx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  urx_framer #(.OSR(OSR), .DW(DW)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_s), .nine_i(nine_bit_i),
    .done_o(f_done), .data_o(f_data), .b9_o(f_b9), .stop_o(f_stop), .brk_o(f_brk)
  );

  urx_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .done_i(f_done), .data_i(f_data), .b9_i(f_b9),
    .stop_i(f_stop), .brk_i(f_brk), .ready_i(rd_ready_i), .stat_rd_i(stat_rd_i),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .b9_o(bit9_o), .fe_o(fe_o),
    .ovr_o(ovr_o), .brk_o(brk_o)
  );

  assert_reset_R1: assert property (@(posedge clk) $rose(rst_n) |-> (!rd_valid_o && !fe_o && !ovr_o && !brk_o));
endmodule

// File: tb/urx_break_rx_tb_top.sv
module urx_break_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 0, rst_n = 0, rx = 1, tick = 0, nine = 0, ready = 0, stat_rd = 0;
  logic [7:0] data;
  logic valid, b9, fe, ovr, brk;

  int vectors = 0, errors = 0, div = 0;
  bit cmp_en = 0, finished = 0;
  string cur_req = "R1";

  bit e_valid, e_b9, e_fe, e_ovr, e_brk, e_arm;
  logic [7:0] e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == 0);
  end

  urx_break_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .nine_bit_i(nine),
    .rd_data_o(data), .rd_valid_o(valid), .rd_ready_i(ready), .bit9_o(b9),
    .stat_rd_i(stat_rd), .fe_o(fe), .ovr_o(ovr), .brk_o(brk)
  );

  always @(negedge clk) if (cmp_en) begin
    vectors++;
    if ({valid, data, b9, fe, ovr, brk} !== {e_valid, e_data, e_b9, e_fe, e_ovr, e_brk}) begin
      errors++;
      $display("FAIL %s: got v=%b d=%h b9=%b fe=%b ov=%b bk=%b exp v=%b d=%h b9=%b fe=%b ov=%b bk=%b",
        cur_req, valid, data, b9, fe, ovr, brk, e_valid, e_data, e_b9, e_fe, e_ovr, e_brk);
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_done(input logic [8:0] bits, input bit nm, input bit stopv);
    logic [7:0] d = bits[7:0];
    bit x9 = nm ? bits[8] : 1'b0;
    if (!stopv && d == 0 && !x9) begin
      if (e_valid) e_ovr = 1;
      e_valid = 1; e_data = 0; e_b9 = 0; e_fe = 1; e_brk = 1;
    end else if (e_valid) begin
      e_ovr = 1;
    end else begin
      e_valid = 1; e_data = d; e_b9 = x9;
      if (!stopv) e_fe = 1;
    end
  endtask

  task automatic send(input logic [8:0] bits, input bit nm, input bit stopv,
                      input int hold, input bit glitch, input string req);
    int nb = nm ? 9 : 8;
    cmp_en = 0;
    cur_req = req;
    nine = nm;
    rx = 0; clocks(BITC);
    for (int i = 0; i < nb; i++) begin
      rx = bits[i];
      if (glitch && i == 0) begin
        clocks(30); rx = ~bits[i]; clocks(2); rx = bits[i]; clocks(BITC - 32);
      end else clocks(BITC);
    end
    rx = stopv; clocks(BITC + 16);
    model_done(bits, nm, stopv);
    cmp_en = 1;
    clocks(hold);
    rx = 1; clocks(BITC);
  endtask

  task automatic data_read(input string req);
    cur_req = req;
    ready = 1; clocks(1);
    if (e_valid) begin
      e_valid = 0;
      if (e_arm) begin e_fe = 0; e_ovr = 0; e_brk = 0; end
      e_arm = 0;
    end
    ready = 0; clocks(4);
  endtask

  task automatic stat_read(input string req);
    cur_req = req;
    stat_rd = 1; clocks(1);
    e_arm = 1;
    stat_rd = 0; clocks(2);
  endtask

  initial begin
    e_valid = 0; e_data = 0; e_b9 = 0; e_fe = 0; e_ovr = 0; e_brk = 0; e_arm = 0;
    clocks(5);
    cur_req = "R1"; cmp_en = 1;
    clocks(3);
    rst_n = 1;
    clocks(20);
    // R2: short low pulse rejected at the start-bit mid check
    cur_req = "R2"; rx = 0; clocks(12); rx = 1; clocks(400);
    // R3: eight-bit character with a one-sample glitch on bit 0
    send(9'h0A5, 0, 1, 0, 1, "R3");
    clocks(50);
    data_read("R5");
    // R6: overrun keeps the first character
    send(9'h03C, 0, 1, 0, 0, "R5");
    send(9'h055, 0, 1, 0, 0, "R6");
    data_read("R11");
    send(9'h011, 0, 1, 0, 0, "R11");
    stat_read("R11"); data_read("R11");
    // R4: nine-bit character
    send(9'h196, 1, 1, 0, 0, "R4");
    data_read("R4");
    // R7: framing error with nonzero data
    send(9'h080, 0, 0, 0, 0, "R7");
    data_read("R11");
    send(9'h022, 0, 1, 0, 0, "R11");
    stat_read("R11"); data_read("R11");
    // R7: nine-bit, only the ninth bit set, stop 0
    send(9'h100, 1, 0, 0, 0, "R7");
    stat_read("R7"); data_read("R7");
    // R8 and R10: break with line held low afterwards
    send(9'h000, 0, 0, 40 * BITC / 4, 0, "R10");
    // R9: second break while the first is unread
    send(9'h000, 0, 0, 0, 0, "R9");
    stat_read("R9"); data_read("R9");
    // R8: nine-bit break
    send(9'h000, 1, 0, 0, 0, "R8");
    clocks(20);
    stat_read("R8"); data_read("R8");
    send(9'h0C3, 0, 1, 0, 0, "R3");
    data_read("R5");
    clocks(20);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule